// File: doc/BRIEF.md
# Split-Half GPIO Controller with Per-Signal Hold

This block controls a bank of general-purpose pad signals, 32 by default, arranged as two 16-bit halves. Each half has its own small set of word registers on a simple single-cycle register port:

- a direction mask;
- an output data register;
- a read-only view of the synchronised pad inputs;
- two write-only strobes that put chosen signals into a "hold" state or release them from it.

A held signal is forced low. If the signal is an output, its pad is driven with 0. If it is an input, its sampled value reads back as 0. The stored direction and output data are kept, so releasing the hold restores the previous behaviour.

Software sets a hold by writing ones to the hold-set register and removes it by writing ones to the hold-release register. Zero bits in either write leave the other signals alone, so no read-modify-write is needed.

The pad inputs pass through a multi-stage synchroniser before the hold mask is applied. The register port has no back-pressure: a write takes effect at the clock edge where `reg_wr` is sampled high. A read is answered one cycle later, with `reg_rvalid` high for exactly that one cycle.

Top module: `gpio_hold_ctrl`

## Requirements

**Register address.** `reg_addr` is formed as {kind[2:0], half index}. Half 0 holds signals 15:0 and sits at the lower address of each pair. The kind codes are:

| Kind | Register |
|------|----------|
| 0 | Direction |
| 1 | Output data |
| 2 | Pin input |
| 3 | Hold set |
| 4 | Hold release |
| 5–7 | Unmapped |

- R1: After reset every signal is an input (`pad_oe` all 0), no hold is active, the output data is 0 (`pad_out` all 0), and `reg_rvalid` is 0.
- R2: Writing the direction register (kind 0) of a half sets `pad_oe` for that half to the written value. Bit value 1 means output and 0 means input. Reading kind 0 returns the current mask. `pad_oe` changes only through kind 0 writes.
- R3: Writing the output data register (kind 1) sets `pad_out` for non-held signals of that half to the written value. Reading kind 1 returns the stored value. `pad_out` changes only in the cycle after a write.
- R4: Writing kind 3 with bit n = 1 puts signal n of that half into hold. Bits written as 0 leave the hold state of their signal unchanged.
- R5: A held output keeps `pad_oe` at 1 and drives `pad_out` 0. A held input reads 0 in the pin input register (kind 2), whatever its pad level.
- R6: Writing kind 4 with bit n = 1 releases the hold on signal n. Bits written as 0 leave their signal unchanged, and a released output again drives its stored data.
- R7: Reads of kind 3 and kind 4 always return 0.
- R8: The pin input register reports `pad_in` through a two-stage synchroniser. A pad change made just before a read request is not yet visible in that read, but it is visible once two clock edges have passed.
- R9: The two halves are independent. A write to one half changes no output or register of the other half.
- R10: `reg_rvalid` is high exactly in the cycle after a cycle with `reg_rd` high. For unmapped kinds 5 to 7, reads return 0 and writes change nothing.
- R11: The pin input register is read-only. Writing kind 2 changes no output and no register.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one register per cycle |
| reg_rd | input | 1 | Read request |
| reg_addr | input | ADDR_W (4) | {kind, half index} |
| reg_wdata | input | HALF_W (16) | Write data for one half |
| reg_rdata | output | HALF_W (16) | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read response strobe |
| pad_in | input | NUM_SIG (32) | Asynchronous pad input levels |
| pad_out | output | NUM_SIG (32) | Pad output data after hold gating |
| pad_oe | output | NUM_SIG (32) | Pad output enable (1 = drive) |

## Verification

The bench builds the block with `HALF_W=4`, `NUM_HALVES=2` and `SYNC_STAGES=2`. At that size every value of each 4-bit register is reachable in a short run.

- Every direction, output-data, hold-set and hold-release pattern is swept on both halves.
- The pin register is checked over all 256 combinations of low-half hold mask and pad level, so every held and non-held input case is covered.

The same configuration also brings the synchroniser latency, the unmapped kinds and the read-only pin register within a few cycles.

// File: rtl/gpio_hold_pkg.sv
package gpio_hold_pkg;
  // Register kind occupies the top three address bits.
  typedef enum logic [2:0] {
    KIND_DIR  = 3'd0,
    KIND_DOUT = 3'd1,
    KIND_PIN  = 3'd2,
    KIND_SET  = 3'd3,
    KIND_CLR  = 3'd4
  } reg_kind_e;

  localparam logic [2:0] KIND_LAST = 3'd4;

  function automatic logic kind_mapped(input logic [2:0] k);
    return k <= KIND_LAST;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_half_bank.sv
module gpio_half_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_dout,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] in_sync,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] pin_val,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] hold_q;
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  assign set_mask = wr_set ? wdata : '0;
  assign clr_mask = wr_clr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      hold_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_dout) dout_q <= wdata;
      hold_q <= (hold_q | set_mask) & ~clr_mask;
    end
  end

  // Hold gates both directions; stored data is preserved for release.
  assign pad_o   = dout_q & ~hold_q;
  assign pad_oe  = dir_q;
  assign pin_val = in_sync & ~hold_q;
endmodule

// File: rtl/gpio_regif.sv
module gpio_regif
  import gpio_hold_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int NUM_HALVES = 2,
  parameter int HALF_AW    = 1,
  parameter int ADDR_W     = 4,
  localparam int NUM_SIG   = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [NUM_SIG-1:0]    dir_all,
  input  logic [NUM_SIG-1:0]    dout_all,
  input  logic [NUM_SIG-1:0]    pin_all,
  output logic [NUM_HALVES-1:0] wr_dir,
  output logic [NUM_HALVES-1:0] wr_dout,
  output logic [NUM_HALVES-1:0] wr_set,
  output logic [NUM_HALVES-1:0] wr_clr,
  output logic [HALF_W-1:0]     reg_rdata,
  output logic                  reg_rvalid
);
  logic [2:0]         kind_raw;
  reg_kind_e          kind;
  logic [HALF_AW-1:0] half_idx;
  int                 hsel;
  logic               addr_ok;
  logic [HALF_W-1:0]  rd_mux;

  assign kind_raw = reg_addr[ADDR_W-1 -: 3];
  assign kind     = reg_kind_e'(kind_raw);
  assign half_idx = reg_addr[HALF_AW-1:0];
  assign hsel     = int'(half_idx);
  assign addr_ok  = kind_mapped(kind_raw) && (hsel < NUM_HALVES);

  generate
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_strobe
      logic hit;
      assign hit        = reg_wr && addr_ok && (half_idx == HALF_AW'(h));
      assign wr_dir[h]  = hit && (kind == KIND_DIR);
      assign wr_dout[h] = hit && (kind == KIND_DOUT);
      assign wr_set[h]  = hit && (kind == KIND_SET);
      assign wr_clr[h]  = hit && (kind == KIND_CLR);
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (kind)
        KIND_DIR:  rd_mux = dir_all[hsel*HALF_W +: HALF_W];
        KIND_DOUT: rd_mux = dout_all[hsel*HALF_W +: HALF_W];
        KIND_PIN:  rd_mux = pin_all[hsel*HALF_W +: HALF_W];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_hold_ctrl.sv
module gpio_hold_ctrl #(
  parameter int HALF_W      = 16,
  parameter int NUM_HALVES  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SIG    = HALF_W * NUM_HALVES,
  localparam int HALF_AW    = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1,
  localparam int ADDR_W     = 3 + HALF_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [HALF_W-1:0]  reg_wdata,
  output logic [HALF_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  input  logic [NUM_SIG-1:0] pad_in,
  output logic [NUM_SIG-1:0] pad_out,
  output logic [NUM_SIG-1:0] pad_oe
);
  logic [NUM_SIG-1:0]    in_sync;
  logic [NUM_SIG-1:0]    dir_all;
  logic [NUM_SIG-1:0]    dout_all;
  logic [NUM_SIG-1:0]    pin_all;
  logic [NUM_HALVES-1:0] wr_dir;
  logic [NUM_HALVES-1:0] wr_dout;
  logic [NUM_HALVES-1:0] wr_set;
  logic [NUM_HALVES-1:0] wr_clr;

  gpio_sync #(.W(NUM_SIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  gpio_regif #(
    .HALF_W     (HALF_W),
    .NUM_HALVES (NUM_HALVES),
    .HALF_AW    (HALF_AW),
    .ADDR_W     (ADDR_W)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .dir_all    (dir_all),
    .dout_all   (dout_all),
    .pin_all    (pin_all),
    .wr_dir     (wr_dir),
    .wr_dout    (wr_dout),
    .wr_set     (wr_set),
    .wr_clr     (wr_clr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  generate
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      gpio_half_bank #(.W(HALF_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_dir[h]),
        .wr_dout (wr_dout[h]),
        .wr_set  (wr_set[h]),
        .wr_clr  (wr_clr[h]),
        .wdata   (reg_wdata),
        .in_sync (in_sync[h*HALF_W +: HALF_W]),
        .dir_q   (dir_all[h*HALF_W +: HALF_W]),
        .dout_q  (dout_all[h*HALF_W +: HALF_W]),
        .pin_val (pin_all[h*HALF_W +: HALF_W]),
        .pad_o   (pad_out[h*HALF_W +: HALF_W]),
        .pad_oe  (pad_oe[h*HALF_W +: HALF_W])
      );
    end
  endgenerate
endmodule

// File: rtl/gpio_hold_chk.sv
module gpio_hold_chk #(
  parameter int HALF_W     = 16,
  parameter int NUM_HALVES = 2,
  parameter int HALF_AW    = 1,
  parameter int ADDR_W     = 4,
  localparam int NUM_SIG   = HALF_W * NUM_HALVES
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [HALF_W-1:0]  reg_wdata,
  input logic [HALF_W-1:0]  reg_rdata,
  input logic               reg_rvalid,
  input logic [NUM_SIG-1:0] pad_out,
  input logic [NUM_SIG-1:0] pad_oe
);
  localparam logic [ADDR_W-1:0] A_DIR0 = {3'd0, {HALF_AW{1'b0}}};
  localparam logic [ADDR_W-1:0] A_SET0 = {3'd3, {HALF_AW{1'b0}}};

  logic [2:0] kind;
  assign kind = reg_addr[ADDR_W-1 -: 3];

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R7
  strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (kind == 3'd3 || kind == 3'd4)) |=> (reg_rdata == '0));

  // R2
  oe_tracks_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIR0) |=> (pad_oe[HALF_W-1:0] == $past(reg_wdata)));

  // R2
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && kind == 3'd0) |=> $stable(pad_oe));

  // R3
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(pad_out));

  // R4
  set_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SET0) |=>
      ((pad_out[HALF_W-1:0] & $past(reg_wdata)) == '0));

  // R4
  set_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SET0) |=>
      (((pad_out[HALF_W-1:0] ^ $past(pad_out[HALF_W-1:0])) & ~$past(reg_wdata)) == '0));
endmodule

bind gpio_hold_ctrl gpio_hold_chk #(
  .HALF_W     (HALF_W),
  .NUM_HALVES (NUM_HALVES),
  .HALF_AW    (HALF_AW),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe)
);

// File: tb/sim_gpio_hold_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_hold_ctrl;
  localparam int HW = 4;
  localparam int NH = 2;
  localparam int NS = HW * NH;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [HW-1:0] reg_wdata = '0;
  logic [HW-1:0] reg_rdata;
  logic          reg_rvalid;
  logic [NS-1:0] pad_in = '0;
  logic [NS-1:0] pad_out;
  logic [NS-1:0] pad_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_hold_ctrl #(.HALF_W(HW), .NUM_HALVES(NH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [AW-1:0] ad(input int kind, input int half);
    return AW'(kind * 2 + half);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [HW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [HW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R10 rvalid", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [HW-1:0] d;
    logic [NS-1:0] oe_s, out_s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 32'd0);
    chk("R1 pad_out", 32'(pad_out), 32'd0);
    chk("R1 rvalid", 32'(reg_rvalid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rvalid idle", 32'(reg_rvalid), 32'd0);
    for (int h = 0; h < NH; h++) begin
      rd(ad(0, h), d); chk("R1 dir read", 32'(d), 32'd0);
      rd(ad(1, h), d); chk("R1 dout read", 32'(d), 32'd0);
    end

    // R2 / R9 direction sweep
    for (int h = 0; h < NH; h++) begin
      for (int p = 0; p < 16; p++) begin
        wr(ad(0, h), HW'(p));
        chk("R2 pad_oe half", 32'((pad_oe >> (h*HW)) & 4'hF), 32'(p));
        chk("R9 other half oe", 32'((pad_oe >> ((1-h)*HW)) & 4'hF), 32'd0);
        rd(ad(0, h), d); chk("R2 dir read", 32'(d), 32'(p));
      end
      wr(ad(0, h), '0);
    end

    // R3 output data sweep, all outputs
    wr(ad(0, 0), 4'hF); wr(ad(0, 1), 4'hF);
    for (int h = 0; h < NH; h++) begin
      for (int p = 0; p < 16; p++) begin
        wr(ad(1, h), HW'(p));
        chk("R3 pad_out half", 32'((pad_out >> (h*HW)) & 4'hF), 32'(p));
        rd(ad(1, h), d); chk("R3 dout read", 32'(d), 32'(p));
      end
      wr(ad(1, h), 4'hF);
    end

    // R4 / R5 / R9 hold-set sweep
    for (int h = 0; h < NH; h++) begin
      for (int p = 0; p < 16; p++) begin
        wr(ad(4, h), 4'hF);
        wr(ad(3, h), HW'(p));
        chk("R4 R5 held low", 32'((pad_out >> (h*HW)) & 4'hF), 32'(~p & 4'hF));
        chk("R5 oe kept", 32'(pad_oe), 32'hFF);
        chk("R9 other half out", 32'((pad_out >> ((1-h)*HW)) & 4'hF), 32'hF);
        wr(ad(3, h), 4'h0);
        chk("R4 zero write no effect", 32'((pad_out >> (h*HW)) & 4'hF), 32'(~p & 4'hF));
        rd(ad(1, h), d); chk("R5 dout kept", 32'(d), 32'hF);
      end
      wr(ad(4, h), 4'hF);
    end

    // R6 release sweep
    for (int h = 0; h < NH; h++) begin
      for (int p = 0; p < 16; p++) begin
        wr(ad(3, h), 4'hF);
        wr(ad(4, h), HW'(p));
        chk("R6 release", 32'((pad_out >> (h*HW)) & 4'hF), 32'(p));
        wr(ad(4, h), 4'h0);
        chk("R6 zero write no effect", 32'((pad_out >> (h*HW)) & 4'hF), 32'(p));
      end
      wr(ad(4, h), 4'hF);
    end

    // R7 strobe registers read zero
    wr(ad(3, 0), 4'h5);
    for (int h = 0; h < NH; h++) begin
      rd(ad(3, h), d); chk("R7 set read", 32'(d), 32'd0);
      rd(ad(4, h), d); chk("R7 clr read", 32'(d), 32'd0);
    end
    wr(ad(4, 0), 4'hF);

    // R5 / R8 input sweep, all inputs
    wr(ad(0, 0), 4'h0); wr(ad(0, 1), 4'h0);
    for (int hm = 0; hm < 16; hm++) begin
      wr(ad(4, 0), 4'hF);
      wr(ad(3, 0), HW'(hm));
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        pad_in = NS'({4'(~v), 4'(v)});
        repeat (2) @(negedge clk);
        rd(ad(2, 0), d);
        chk("R5 R8 pin low", 32'(d), 32'(v & ~hm & 4'hF));
        if (v == 9) begin
          rd(ad(2, 1), d);
          chk("R9 R8 pin high", 32'(d), 32'(~v & 4'hF));
        end
      end
    end
    wr(ad(4, 0), 4'hF);

    // R8 latency: change just before read is not yet seen
    @(negedge clk); pad_in = 8'h0A;
    repeat (3) @(negedge clk);
    pad_in = 8'h05;
    rd(ad(2, 0), d); chk("R8 not yet visible", 32'(d), 32'hA);
    repeat (2) @(negedge clk);
    rd(ad(2, 0), d); chk("R8 visible", 32'(d), 32'h5);

    // R11 pin register read-only
    wr(ad(0, 0), 4'h3); wr(ad(1, 0), 4'h2);
    oe_s = pad_oe; out_s = pad_out;
    wr(ad(2, 0), 4'hF);
    chk("R11 oe unchanged", 32'(pad_oe), 32'(oe_s));
    chk("R11 out unchanged", 32'(pad_out), 32'(out_s));
    rd(ad(0, 0), d); chk("R11 dir unchanged", 32'(d), 32'h3);
    rd(ad(1, 0), d); chk("R11 dout unchanged", 32'(d), 32'h2);

    // R10 unmapped kinds
    for (int k = 5; k < 8; k++) begin
      for (int h = 0; h < NH; h++) begin
        wr(ad(k, h), 4'hF);
        chk("R10 unmapped oe", 32'(pad_oe), 32'(oe_s));
        chk("R10 unmapped out", 32'(pad_out), 32'(out_s));
        rd(ad(k, h), d); chk("R10 unmapped read", 32'(d), 32'd0);
      end
    end
    rd(ad(1, 0), d); chk("R10 dout after unmapped", 32'(d), 32'h2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule